// File: doc/BRIEF.md
# Parity-Framing Asynchronous Serial Transmitter

This block turns one character into an asynchronous serial frame on a single output line. A frame is one low start bit, then a payload field sent least significant bit first, then high stop bits that fill the frame to its length. A width-select input picks an 8-bit payload field, which gives a 10-bit frame, or a 9-bit field, which gives an 11-bit frame. When parity is on, the generated parity bit takes the place of the field's top bit. The frame length does not change; only the count of true data bits drops by one.

A character is offered with a valid/ready handshake. The width, parity-enable and parity-type inputs are captured together with the character. A baud generator outside the block supplies a one-cycle bit tick. Each frame bit is held on the line for exactly one tick interval. The line is high whenever no frame is in progress. A busy flag stays raised from acceptance until the last stop bit has run its full tick.

Top module: `ser_par_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `busy` is 1 and `in_ready` is 0 until the frame ends.
- R3: After acceptance `txd` stays 1 until the first `bit_tick`. From that tick until the next one, it carries the start bit, which is 0.
- R4: Frame bits leave in order, with the payload least significant bit first. Each bit changes only on a `bit_tick` and is held for one full tick interval.
- R5: With `wide` = 0 the frame is 10 bits long: start, payload field bits 0..7, and one stop bit of value 1. Without parity, field bits 0..7 are `in_data[7:0]`.
- R6: With `wide` = 1 the frame is 11 bits long: start, payload field bits 0..8, and one stop bit of value 1. Without parity, field bits 0..8 are `in_data[8:0]`.
- R7: With `par_en` = 1 the top field bit (bit 7 when `wide` = 0, bit 8 when `wide` = 1) carries the parity of the field bits below it. The `in_data` value at that position has no effect.
- R8: With `par_odd` = 0 the parity bit makes the count of ones in the field even. With `par_odd` = 1 it makes the count odd.
- R9: The `bit_tick` that ends the last stop bit returns `busy` to 0, `in_ready` to 1 and `txd` to 1 in the following cycle. `in_valid` held while busy does not start a new frame.
- R10: Changes on `in_data`, `wide`, `par_en` or `par_odd` during a frame do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period, from the baud generator |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | 9 | Character; bit 8 is used only with `wide` = 1 |
| wide | input | 1 | 0: 8-bit field, 10-bit frame; 1: 9-bit field, 11-bit frame |
| par_en | input | 1 | 1: parity replaces the top field bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| txd | output | 1 | Serial line output, idles high |
| busy | output | 1 | Frame pending or in progress |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse and never holds high for two cycles in a row. The bench enforces this by raising the tick for one clock and then leaving at least one quiet clock before the next. The assertions also assume the baud generator keeps ticking while a frame is pending. The directed tasks give every frame its full number of ticks and never leave one half finished. Input changes during a frame are allowed. One scenario scrambles every configuration input and the data mid-frame while holding `in_valid` high.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ser_tx_field.sv
module ser_tx_field #(
  parameter int FIELD_MAX = 9
) (
  input  logic [FIELD_MAX-1:0] data,
  input  logic                 wide,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [FIELD_MAX-1:0] field
);
  localparam int NARROW_TOP = FIELD_MAX - 2;
  localparam int WIDE_TOP   = FIELD_MAX - 1;

  logic par_narrow;
  logic par_wide;

  // parity over the bits below the chosen field top, flipped for odd type
  assign par_narrow = (^data[NARROW_TOP-1:0]) ^ par_odd;
  assign par_wide   = (^data[WIDE_TOP-1:0]) ^ par_odd;

  for (genvar i = 0; i < FIELD_MAX; i++) begin : g_bit
    if (i < NARROW_TOP) begin : g_plain
      assign field[i] = data[i];
    end else if (i == NARROW_TOP) begin : g_ntop
      assign field[i] = (!wide && par_en) ? par_narrow : data[i];
    end else begin : g_wtop
      always_comb begin
        if (!wide)       field[i] = 1'b1;
        else if (par_en) field[i] = par_wide;
        else             field[i] = data[i];
      end
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               lsb
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;
  logic               sr_en;

  assign sr_en = load | shift;

  always_comb begin
    if (load) sr_d = frame_in;
    else      sr_d = {1'b1, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '1;
    else if (sr_en) sr_q <= sr_d;
  end

  assign lsb = sr_q[0];

  // R4
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sr_q));
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int FRAME_W = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      tick,
  input  logic      wide,
  output tx_state_e state,
  output logic      shift
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wide_q, wide_d;
  logic             cnt_en, wide_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    wide_d  = wide;
    cnt_en  = 1'b0;
    wide_en = 1'b0;
    shift   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_WAIT;
          wide_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tick) begin
          st_d   = ST_SEND;
          cnt_d  = wide_q ? LEN_WIDE : LEN_NARROW;
          cnt_en = 1'b1;
        end
      end
      ST_SEND: begin
        if (tick) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - CNT_ONE;
          shift  = 1'b1;
          if (cnt_q == CNT_ONE) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (wide_en) wide_q <= wide_d;
    end
  end

  assign state = st_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_WIDE);
  // R2
  accept_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st_q == ST_WAIT));
  // R6
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && tick && wide_q) |=> (cnt_q == LEN_WIDE));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ser_par_tx.sv
module ser_par_tx
  import ser_tx_pkg::*;
#(
  parameter int FIELD_MAX = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FIELD_MAX-1:0] in_data,
  input  logic                 wide,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 txd,
  output logic                 busy
);
  localparam int FRAME_W = FIELD_MAX + 2;

  tx_state_e          state;
  logic               accept;
  logic               shift;
  logic               lsb;
  logic [FIELD_MAX-1:0] field;
  logic [FRAME_W-1:0] frame;

  assign in_ready = (state == ST_IDLE);
  assign busy     = !in_ready;
  assign accept   = in_valid && in_ready;
  assign frame    = {1'b1, field, 1'b0};

  ser_tx_field #(.FIELD_MAX(FIELD_MAX)) u_field (
    .data    (in_data),
    .wide    (wide),
    .par_en  (par_en),
    .par_odd (par_odd),
    .field   (field)
  );

  ser_tx_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .tick   (bit_tick),
    .wide   (wide),
    .state  (state),
    .shift  (shift)
  );

  ser_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .shift    (shift),
    .frame_in (frame),
    .lsb      (lsb)
  );

  assign txd = (state == ST_SEND) ? lsb : 1'b1;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SEND) |-> txd);
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && bit_tick) |=> !txd);
  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(txd));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !bit_tick) |=> busy);
  // R8
  par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && par_en && !wide) |-> ((^field[FIELD_MAX-2:0]) == par_odd));
endmodule

// File: tb/sim_ser_par_tx.sv
module sim_ser_par_tx;
  localparam int CLK_PERIOD = 10;
  localparam int FM = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FM-1:0] in_data = '0;
  logic          wide = 1'b0;
  logic          par_en = 1'b0;
  logic          par_odd = 1'b0;
  logic          txd;
  logic          busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_par_tx #(.FIELD_MAX(FM)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .wide(wide), .par_en(par_en),
    .par_odd(par_odd), .txd(txd), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected frame from the requirements: bit 0 start, field, stops
  function automatic logic [10:0] exp_frame(input logic [8:0] d, input bit w,
                                             input bit pe, input bit po);
    logic [10:0] f;
    int top;
    int ones;
    f = '1;
    f[0] = 1'b0;
    top = w ? 8 : 7;
    ones = 0;
    for (int i = 0; i <= top; i++) f[i+1] = d[i];
    if (pe) begin
      for (int i = 0; i < top; i++) ones += int'(d[i]);
      f[top+1] = (ones % 2 == 1) ? ~po : po;
    end
    return f;
  endfunction

  task automatic pulse_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input bit w, input bit pe,
                            input bit po, input bit scramble, input string tag);
    logic [10:0] f;
    int len;
    f = exp_frame(d, w, pe, po);
    len = w ? 11 : 10;
    @(negedge clk);
    in_data = d; wide = w; par_en = pe; par_odd = po; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == 1'b1 && in_ready == 1'b0, {"R2 accept ", tag}, int'(busy), 1);
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, {"R3 wait high ", tag}, int'(txd), 1);
    for (int b = 0; b < len; b++) begin
      pulse_tick();
      if (scramble && b == 2) begin
        in_data = ~d; wide = ~w; par_en = ~pe; par_odd = ~po; in_valid = 1'b1;
      end
      chk(txd == f[b], $sformatf("R4/R5/R6/R7/R8 bit%0d %s", b, tag), int'(txd), int'(f[b]));
      repeat (2) @(negedge clk);
      chk(txd == f[b], $sformatf("R4 hold bit%0d %s", b, tag), int'(txd), int'(f[b]));
      chk(busy == 1'b1, $sformatf("R9 busy bit%0d %s", b, tag), int'(busy), 1);
    end
    in_valid = 1'b0;
    pulse_tick();
    chk(busy == 1'b0 && in_ready == 1'b1, {"R9 end ", tag}, int'(busy), 0);
    chk(txd == 1'b1, {"R9 idle line ", tag}, int'(txd), 1);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
  endtask

  task automatic t_narrow_plain();  send_frame(9'h0A5, 0, 0, 0, 0, "R5 narrow"); endtask
  task automatic t_narrow_even();   send_frame(9'h0B3, 0, 1, 0, 0, "R7 narrow even"); endtask
  task automatic t_narrow_odd();    send_frame(9'h033, 0, 1, 1, 0, "R8 narrow odd"); endtask
  task automatic t_wide_plain();    send_frame(9'h13C, 1, 0, 0, 0, "R6 wide"); endtask
  task automatic t_wide_even();     send_frame(9'h0F1, 1, 1, 0, 0, "R7 wide even"); endtask
  task automatic t_wide_odd();      send_frame(9'h1F1, 1, 1, 1, 0, "R8 wide odd"); endtask
  task automatic t_scramble();      send_frame(9'h05A, 0, 1, 1, 1, "R10 scramble"); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_plain();
    t_narrow_even();
    t_narrow_odd();
    t_wide_plain();
    t_wide_even();
    t_wide_odd();
    t_scramble();
    t_narrow_plain();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule